// File: doc/BRIEF.md
# Cell Dataflow Handshake Controller

This block is the flow-control logic of one tile in a coarse-grained array of small processing cells. Each cell has two input-side memory banks (A and B) that are filled by upstream cells. It also has two output ports (L and R), and each output port feeds up to two downstream cells. The controller decides when the cell's local program may run. It tracks a sticky "data ready" flag for each input bank, and it watches the memory-state flags of the four downstream positions. It issues a start pulse when the local data is complete and every connected downstream memory has been emptied.

When the sequencer reports that the run has finished, the controller does two things. It sends a one-cycle ready strobe to every connected downstream position, and it drops its own input flags back to not ready. The cell therefore alternates between waiting and processing. The connection masks describe which inputs and which downstream positions are wired up. They are sampled while reset is high and are held fixed afterwards. An unconnected input counts as permanently ready. An unconnected downstream position counts as permanently empty.

Top module: `cell_flow_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `running`, `start` and `dn_rdy_strobe` are all 0.
- R2: A run begins only when every connected input flag is set and no connected downstream position is full. The cell must also be waiting. On that edge `running` rises and `start` is high for exactly that first processing cycle. The start edge falls two clock edges after the last needed input strobe is driven. Input bit 0 is bank A and bit 1 is bank B.
- R3: An input whose bit in `cfg_in_conn` is 0 counts as always ready, and strobes on it are ignored.
- R4: A downstream position whose bit in `cfg_dn_conn` is 1 and whose `dn_full` bit is 1 blocks a start. A full flag on an unconnected position has no effect. Downstream bits are ordered as follows: bit 0 is the first cell on L, bit 1 the second on L, bit 2 the first on R, bit 3 the second on R.
- R5: Once processing, the cell stays processing, with no further start, until `done` is seen, whatever the input strobes and full flags do.
- R6: `done` while processing returns the cell to waiting on the next edge. In the cycle after that edge, `dn_rdy_strobe` equals the connected downstream mask, and it is 0 in the following cycle. `done` while waiting is ignored.
- R7: Completing a run clears the local input flags, so input strobes received before the `done` cycle do not count towards the next run.
- R8: The connection masks are captured only while reset is high. Changing them afterwards does not alter start conditions or strobe targets.
- R9: An input strobe arriving in the same cycle as `done` is kept, and it counts towards the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the connection masks |
| cfg_in_conn | input | NUM_IN | Input connection mask (bit 0 = bank A, bit 1 = bank B) |
| cfg_dn_conn | input | NUM_DN | Downstream connection mask (L first, L second, R first, R second) |
| in_rdy_strobe | input | NUM_IN | One-cycle ready strobes from upstream, per input bank |
| dn_full | input | NUM_DN | Memory-state flags of the downstream cells (1 = holds unconsumed data) |
| done | input | 1 | Run-complete pulse from the sequencer |
| start | output | 1 | One-cycle pulse in the first processing cycle |
| running | output | 1 | High while the cell is processing |
| dn_rdy_strobe | output | NUM_DN | One-cycle ready strobes to connected downstream cells |

## Verification
The hardest case to reach is an upstream ready strobe that lands in exactly the same cycle as `done`. This tests whether set or clear wins on the sticky flag. The stimulus reaches it by running a full start sequence, then raising `done` together with a single bank strobe on a cycle whose timing is computed from the start. A lone strobe on the other bank must then be enough to launch the next run. A second difficult case is a full flag on an unconnected position, which is covered by rearranging `dn_full` while both input flags are already latched. The masks are then changed after reset and reloaded by a second reset, so that the capture-only-in-reset rule is checked with two different wirings.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_PROC = 1'b1
  } cfc_state_e;
endpackage

// File: rtl/cfc_cfg_hold.sv
// Captures a static configuration mask while reset is asserted.
module cfc_cfg_hold #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cfg_d,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cfc_in_tracker.sv
// Sticky per-bank ready flags; unconnected banks count as ready.
module cfc_in_tracker #(
  parameter int NUM_IN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] conn,
  input  logic [NUM_IN-1:0] strobe,
  input  logic              clear,
  output logic              all_ready
);
  logic [NUM_IN-1:0] flag_q;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                        flag_q[i] <= 1'b0;
      else if (strobe[i] && conn[i])  flag_q[i] <= 1'b1;  // new data wins over clear
      else if (clear)                 flag_q[i] <= 1'b0;
    end
  end

  assign all_ready = &(flag_q | ~conn);
endmodule

// File: rtl/cfc_dn_gate.sv
// Downstream readiness check and ready-strobe generator.
module cfc_dn_gate #(
  parameter int NUM_DN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_DN-1:0] conn,
  input  logic [NUM_DN-1:0] full,
  input  logic              fire,
  output logic              all_empty,
  output logic [NUM_DN-1:0] strobe
);
  assign all_empty = ~|(full & conn);

  always_ff @(posedge clk) begin
    if (rst)       strobe <= '0;
    else if (fire) strobe <= conn;
    else           strobe <= '0;
  end
endmodule

// File: rtl/cfc_seq_fsm.sv
// Two-state wait/process sequencer with registered start pulse.
module cfc_seq_fsm
  import cfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_ready,
  input  logic dn_empty,
  input  logic done,
  output logic fire,
  output logic start,
  output logic running
);
  cfc_state_e state_q;
  logic       launch;

  assign launch  = (state_q == ST_WAIT) && in_ready && dn_empty;
  assign fire    = (state_q == ST_PROC) && done;
  assign running = (state_q == ST_PROC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      start   <= 1'b0;
    end else begin
      start <= launch;
      if (launch)    state_q <= ST_PROC;
      else if (fire) state_q <= ST_WAIT;
    end
  end
endmodule

// File: rtl/cell_flow_ctrl.sv
module cell_flow_ctrl #(
  parameter  int NUM_IN  = 2,
  parameter  int NUM_OUT = 2,
  parameter  int FANOUT  = 2,
  localparam int NUM_DN  = NUM_OUT * FANOUT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] cfg_in_conn,
  input  logic [NUM_DN-1:0] cfg_dn_conn,
  input  logic [NUM_IN-1:0] in_rdy_strobe,
  input  logic [NUM_DN-1:0] dn_full,
  input  logic              done,
  output logic              start,
  output logic              running,
  output logic [NUM_DN-1:0] dn_rdy_strobe
);
  logic [NUM_IN-1:0] in_conn_q;
  logic [NUM_DN-1:0] dn_conn_q;
  logic              in_ready;
  logic              dn_empty;
  logic              fire;

  cfc_cfg_hold #(.W(NUM_IN)) u_in_cfg (
    .clk(clk), .rst(rst), .cfg_d(cfg_in_conn), .cfg_q(in_conn_q)
  );

  cfc_cfg_hold #(.W(NUM_DN)) u_dn_cfg (
    .clk(clk), .rst(rst), .cfg_d(cfg_dn_conn), .cfg_q(dn_conn_q)
  );

  cfc_in_tracker #(.NUM_IN(NUM_IN)) u_track (
    .clk(clk), .rst(rst), .conn(in_conn_q), .strobe(in_rdy_strobe),
    .clear(fire), .all_ready(in_ready)
  );

  cfc_dn_gate #(.NUM_DN(NUM_DN)) u_gate (
    .clk(clk), .rst(rst), .conn(dn_conn_q), .full(dn_full),
    .fire(fire), .all_empty(dn_empty), .strobe(dn_rdy_strobe)
  );

  cfc_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .in_ready(in_ready), .dn_empty(dn_empty),
    .done(done), .fire(fire), .start(start), .running(running)
  );
endmodule

// File: rtl/cell_flow_ctrl_chk.sv
module cell_flow_ctrl_chk #(
  parameter int NUM_DN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              start,
  input logic              running,
  input logic [NUM_DN-1:0] dn_full,
  input logic [NUM_DN-1:0] dn_conn,
  input logic [NUM_DN-1:0] dn_rdy_strobe
);
  a_r2_start_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> start);

  a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  a_r4_no_start_blocked: assert property (@(posedge clk) disable iff (rst)
    start |-> $past((dn_full & dn_conn) == '0));

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    (running && !done) |=> running);

  a_r6_strobe_on_done: assert property (@(posedge clk) disable iff (rst)
    (running && done) |=> (!running && dn_rdy_strobe == dn_conn));

  a_r6_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    (dn_rdy_strobe != '0) |-> $past(running && done));
endmodule

bind cell_flow_ctrl cell_flow_ctrl_chk #(.NUM_DN(NUM_DN)) u_chk (
  .clk(clk), .rst(rst), .done(done), .start(start), .running(running),
  .dn_full(dn_full), .dn_conn(dn_conn_q), .dn_rdy_strobe(dn_rdy_strobe)
);

// File: tb/cell_flow_ctrl_bench.sv
module cell_flow_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_in_conn = 2'b11;
  logic [3:0] cfg_dn_conn = 4'b0101;
  logic [1:0] in_rdy_strobe = 2'b00;
  logic [3:0] dn_full = 4'b0000;
  logic       done = 1'b0;
  logic       start, running;
  logic [3:0] dn_rdy_strobe;

  int checks = 0;
  int errors = 0;
  int drv_cyc = 0;
  int mon_cyc = 0;
  bit finished = 0;

  typedef struct {
    int         cyc;
    logic       run;
    logic       st;
    logic [3:0] pls;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  cell_flow_ctrl u_cell_flow_ctrl (
    .clk(clk), .rst(rst), .cfg_in_conn(cfg_in_conn), .cfg_dn_conn(cfg_dn_conn),
    .in_rdy_strobe(in_rdy_strobe), .dn_full(dn_full), .done(done),
    .start(start), .running(running), .dn_rdy_strobe(dn_rdy_strobe)
  );

  task automatic tick();
    @(negedge clk);
    drv_cyc++;
  endtask

  task automatic expect_o(input int d, input logic r, input logic s,
                          input logic [3:0] p, input string tag);
    exp_t e;
    e.cyc = drv_cyc + d; e.run = r; e.st = s; e.pls = p; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expect_o(1, 1'b0, 1'b0, 4'b0000, tag);
      tick();
    end
  endtask

  // Monitor: compares outputs at the falling edge against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      mon_cyc++;
      while (exp_q.size() > 0 && exp_q[0].cyc <= mon_cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (e.cyc != mon_cyc || running !== e.run || start !== e.st ||
            dn_rdy_strobe !== e.pls) begin
          errors++;
          $display("FAIL %s: run=%0b start=%0b strobe=%b expected run=%0b start=%0b strobe=%b",
                   e.tag, running, start, dn_rdy_strobe, e.run, e.st, e.pls);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected end of stimulus");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    checks++;
    if (running !== 1'b0 || start !== 1'b0 || dn_rdy_strobe !== 4'b0000) begin
      errors++;
      $display("FAIL R1 in reset: run=%0b start=%0b strobe=%b expected 0 0 0000",
               running, start, dn_rdy_strobe);
    end
    rst = 1'b0;
    expect_o(1, 0, 0, 4'b0000, "R1 after reset");
    tick();

    // R8: masks change after reset, must not matter
    cfg_in_conn = 2'b00;
    cfg_dn_conn = 4'b1111;

    // R2: bank A then bank B
    in_rdy_strobe = 2'b01;
    expect_o(1, 0, 0, 4'b0000, "R2 only A ready");
    tick();
    in_rdy_strobe = 2'b10;
    expect_o(1, 0, 0, 4'b0000, "R2 B pending");
    expect_o(2, 1, 1, 4'b0000, "R2 start edge");
    expect_o(3, 1, 0, 4'b0000, "R2 start single cycle");
    tick();
    in_rdy_strobe = 2'b00;
    tick();
    tick();

    // R5: strobes and full flags while processing
    for (int i = 0; i < 3; i++) begin
      in_rdy_strobe = 2'b11;
      dn_full = 4'b0001;
      expect_o(1, 1, 0, 4'b0000, "R5 hold while processing");
      tick();
    end
    in_rdy_strobe = 2'b00;
    dn_full = 4'b0000;

    // R6/R8: done while processing
    done = 1'b1;
    expect_o(1, 0, 0, 4'b0101, "R6 R8 strobe to captured mask");
    expect_o(2, 0, 0, 4'b0000, "R6 strobe one cycle");
    tick();
    done = 1'b0;
    tick();

    // R7: early strobes were cleared by completion
    idle_check(4, "R7 flags cleared");

    // R6: done while waiting is ignored
    done = 1'b1;
    expect_o(1, 0, 0, 4'b0000, "R6 done while waiting");
    tick();
    done = 1'b0;

    // R9: strobe coinciding with done survives
    in_rdy_strobe = 2'b11;
    expect_o(1, 0, 0, 4'b0000, "R9 pending");
    expect_o(2, 1, 1, 4'b0000, "R9 first start");
    tick();
    in_rdy_strobe = 2'b00;
    tick();
    expect_o(1, 1, 0, 4'b0000, "R9 processing");
    tick();
    done = 1'b1;
    in_rdy_strobe = 2'b01;
    expect_o(1, 0, 0, 4'b0101, "R9 done strobe");
    tick();
    done = 1'b0;
    in_rdy_strobe = 2'b00;
    expect_o(1, 0, 0, 4'b0000, "R9 waiting");
    tick();
    in_rdy_strobe = 2'b10;
    expect_o(1, 0, 0, 4'b0000, "R9 B pending");
    expect_o(2, 1, 1, 4'b0000, "R9 A kept start");
    tick();
    in_rdy_strobe = 2'b00;
    tick();
    expect_o(1, 1, 0, 4'b0000, "R9 running");
    tick();

    // R4: connected full positions block, unconnected ones do not
    dn_full = 4'b0001;
    done = 1'b1;
    expect_o(1, 0, 0, 4'b0101, "R4 prior run done");
    tick();
    done = 1'b0;
    in_rdy_strobe = 2'b11;
    expect_o(1, 0, 0, 4'b0000, "R4 flags loading");
    tick();
    in_rdy_strobe = 2'b00;
    idle_check(2, "R4 blocked by L first");
    dn_full = 4'b0100;
    idle_check(2, "R4 blocked by R first");
    dn_full = 4'b1010;
    expect_o(1, 1, 1, 4'b0000, "R4 unconnected full ignored");
    tick();
    expect_o(1, 1, 0, 4'b0000, "R4 running");
    tick();
    dn_full = 4'b0000;
    done = 1'b1;
    expect_o(1, 0, 0, 4'b0101, "R4 done strobe");
    tick();
    done = 1'b0;

    // R3: second reset with bank B and three positions unconnected
    rst = 1'b1;
    cfg_in_conn = 2'b01;
    cfg_dn_conn = 4'b1000;
    repeat (3) tick();
    rst = 1'b0;
    expect_o(1, 0, 0, 4'b0000, "R1 after second reset");
    tick();
    in_rdy_strobe = 2'b10;
    expect_o(1, 0, 0, 4'b0000, "R3 strobe on unconnected B");
    tick();
    in_rdy_strobe = 2'b00;
    idle_check(2, "R3 B strobe ignored");
    in_rdy_strobe = 2'b01;
    expect_o(1, 0, 0, 4'b0000, "R3 A pending");
    expect_o(2, 1, 1, 4'b0000, "R3 start with A only");
    tick();
    in_rdy_strobe = 2'b00;
    tick();
    expect_o(1, 1, 0, 4'b0000, "R3 running");
    tick();
    done = 1'b1;
    expect_o(1, 0, 0, 4'b1000, "R3 R6 strobe to R second");
    tick();
    done = 1'b0;
    expect_o(1, 0, 0, 4'b0000, "R6 strobe cleared");
    tick();

    repeat (3) tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule